// File: doc/BRIEF.md
# Bootstrap Record Stream Decoder

This block takes a stream of ASCII characters, one per accepted character strobe, as a serial receiver would hand them over. It decodes bootstrap records written as upper-case hexadecimal text. Pairs of hex digits become bytes. The first bytes of a record are a big-endian target address. Next comes a length-and-mode byte, and then the data bytes. Each data byte leaves the block as a single-cycle strobe together with its own target address.

A record with a zero length field carries an execution start address, and the block reports it on a separate strobe. Records have no start character and no checksum. A record ends on any character whose code is below 0x30. Other characters that are not hex digits are dropped without a trace. A record that ends too early, or that ends on half a byte, gives a one-cycle error pulse, and the decoder then waits for the next record.

The block has no memory interface and no jump logic. A downstream loader takes the data strobes and the start-address event.

Top module: `brec_decoder`

## Requirements
- R1: Characters '0'-'9' (0x30-0x39) and 'A'-'F' (0x41-0x46) are hex digits. Two consecutive hex digits form one byte, and the first digit is the high nybble.
- R2: A character with code 0x30 or above that is not a hex digit (for example lower-case letters, ':' or 'G') is ignored. It does not break the pairing of the digits around it and produces no output.
- R3: A character with code below 0x30 (for example CR or LF) ends the current record, and the next hex digit starts a new record.
- R4: A record begins with a 4-byte address, most significant byte first, followed by a length-and-mode byte. In that byte, bits [7:6] are the mode, bit 5 is reserved and ignored, and bits [4:0] are the data length.
- R5: Each data byte gives `data_valid_o` high for exactly one cycle, in the cycle after the clock edge that took in its second digit. It carries `data_addr_o` = record address + byte index, with 32-bit wrap, and the record's mode on `rec_mode_o`.
- R6: A record whose length field is zero gives a one-cycle `start_valid_o` with `start_addr_o` equal to the record address and the mode on `rec_mode_o`. It gives no data strobe.
- R7: A terminator that arrives before the header is complete, or before all declared data bytes have arrived, gives a one-cycle `err_o` in the cycle after the terminator. The next record then decodes normally.
- R8: A terminator that follows an odd number of hex digits in the record gives a one-cycle `err_o`. This holds even when the header and data are otherwise complete.
- R9: A terminator with no hex digits since the previous terminator or reset produces no output and no error.
- R10: Complete hex bytes after the last declared data byte are ignored up to the terminator, and they produce no error.
- R11: After reset, `data_valid_o`, `start_valid_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| char_valid_i | input | 1 | A character is presented this cycle |
| char_i | input | 8 | ASCII character code |
| data_valid_o | output | 1 | One-cycle data byte strobe |
| data_addr_o | output | 32 | Target address of the data byte |
| data_byte_o | output | 8 | Decoded data byte |
| rec_mode_o | output | 2 | Mode field of the current record |
| start_valid_o | output | 1 | One-cycle execution start address strobe |
| start_addr_o | output | 32 | Execution start address |
| err_o | output | 1 | One-cycle malformed record pulse |

## Verification
The assertions assume that each strobed character is one whole character code, with at most one character per cycle. They also assume that `char_i` is only meaningful while `char_valid_i` is high. Under these assumptions no two output events can fall in the same cycle, and two data strobes can never be adjacent. The bench drives every character for exactly one cycle from the falling edge and holds `char_valid_i` low between scenarios. The streams it sends mix ignored characters into both the digit pairs and the header, so the pairing assumptions are exercised at the character boundary and not only at byte boundaries.

// File: rtl/brec_pkg.sv
package brec_pkg;
  typedef enum logic [1:0] {CH_IGNORE, CH_HEX, CH_TERM} char_kind_e;
  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_LEN, ST_DATA, ST_DONE} rec_state_e;
endpackage

// File: rtl/brec_char_class.sv
module brec_char_class
  import brec_pkg::*;
(
  input  logic [7:0] char_i,
  output char_kind_e kind_o,
  output logic [3:0] nyb_o
);
  always_comb begin
    kind_o = CH_IGNORE;
    nyb_o  = 4'h0;
    if (char_i < 8'h30) begin
      kind_o = CH_TERM;
    end else if (char_i <= 8'h39) begin
      kind_o = CH_HEX;
      nyb_o  = char_i[3:0];
    end else if (char_i >= 8'h41 && char_i <= 8'h46) begin
      kind_o = CH_HEX;
      nyb_o  = char_i[3:0] + 4'd9;
    end
  end
endmodule

// File: rtl/brec_nybble_pair.sv
module brec_nybble_pair (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hex_i,
  input  logic       term_i,
  input  logic [3:0] nyb_i,
  output logic       byte_v_o,
  output logic [7:0] byte_o,
  output logic       pend_o
);
  logic       half_q;
  logic [3:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= 1'b0;
      hi_q   <= 4'h0;
    end else if (term_i) begin
      half_q <= 1'b0;
    end else if (hex_i) begin
      if (!half_q) hi_q <= nyb_i;
      half_q <= ~half_q;
    end
  end

  assign byte_v_o = hex_i & half_q;
  assign byte_o   = {hi_q, nyb_i};
  assign pend_o   = half_q;

  assert_term_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_i |=> !pend_o);
  assert_ignore_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hex_i && !term_i) |=> ($stable(half_q) && $stable(hi_q)));
endmodule

// File: rtl/brec_record_fsm.sv
module brec_record_fsm
  import brec_pkg::*;
#(
  parameter int ADDR_BYTES = 4,
  parameter int LEN_W      = 5
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  hex_i,
  input  logic                  term_i,
  input  logic                  byte_v_i,
  input  logic [7:0]            byte_i,
  input  logic                  pend_i,
  output logic                  data_valid_o,
  output logic [8*ADDR_BYTES-1:0] data_addr_o,
  output logic [7:0]            data_byte_o,
  output logic [1:0]            rec_mode_o,
  output logic                  start_valid_o,
  output logic [8*ADDR_BYTES-1:0] start_addr_o,
  output logic                  err_o
);
  localparam int AW    = 8 * ADDR_BYTES;
  localparam int CNT_W = (ADDR_BYTES > 2) ? $clog2(ADDR_BYTES) : 1;
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(ADDR_BYTES - 1);

  rec_state_e       state_q;
  logic [CNT_W-1:0] hdr_cnt_q;
  logic [AW-1:0]    base_q;
  logic [LEN_W-1:0] len_q, idx_q;
  logic [1:0]       mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      hdr_cnt_q     <= '0;
      base_q        <= '0;
      len_q         <= '0;
      idx_q         <= '0;
      mode_q        <= 2'b00;
      data_valid_o  <= 1'b0;
      data_addr_o   <= '0;
      data_byte_o   <= 8'h00;
      start_valid_o <= 1'b0;
      start_addr_o  <= '0;
      err_o         <= 1'b0;
    end else begin
      data_valid_o  <= 1'b0;
      start_valid_o <= 1'b0;
      err_o         <= 1'b0;
      if (term_i) begin
        // incomplete header/data or half byte pending
        err_o   <= pend_i || (state_q != ST_IDLE && state_q != ST_DONE);
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_IDLE: if (hex_i) begin
            state_q   <= ST_ADDR;
            hdr_cnt_q <= '0;
          end
          ST_ADDR: if (byte_v_i) begin
            base_q    <= {base_q[AW-9:0], byte_i};
            hdr_cnt_q <= hdr_cnt_q + 1'b1;
            if (hdr_cnt_q == HDR_LAST) state_q <= ST_LEN;
          end
          ST_LEN: if (byte_v_i) begin
            mode_q <= byte_i[7:6];
            len_q  <= byte_i[LEN_W-1:0];
            idx_q  <= '0;
            if (byte_i[LEN_W-1:0] == '0) begin
              start_valid_o <= 1'b1;
              start_addr_o  <= base_q;
              state_q       <= ST_DONE;
            end else begin
              state_q <= ST_DATA;
            end
          end
          ST_DATA: if (byte_v_i) begin
            data_valid_o <= 1'b1;
            data_addr_o  <= base_q + AW'(idx_q);
            data_byte_o  <= byte_i;
            idx_q        <= idx_q + 1'b1;
            if (idx_q == len_q - 1'b1) state_q <= ST_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  assign rec_mode_o = mode_q;

  assert_one_event_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({data_valid_o, start_valid_o, err_o}));
  assert_data_gap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |=> !data_valid_o);
  assert_err_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> state_q == ST_IDLE);
  assert_start_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_valid_o |-> (state_q == ST_DONE && !data_valid_o));
  assert_empty_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_i && state_q == ST_IDLE && !pend_i) |=> !err_o);
endmodule

// File: rtl/brec_decoder.sv
module brec_decoder
  import brec_pkg::*;
#(
  parameter int ADDR_BYTES = 4,
  parameter int LEN_W      = 5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        char_valid_i,
  input  logic [7:0]  char_i,
  output logic        data_valid_o,
  output logic [31:0] data_addr_o,
  output logic [7:0]  data_byte_o,
  output logic [1:0]  rec_mode_o,
  output logic        start_valid_o,
  output logic [31:0] start_addr_o,
  output logic        err_o
);
  char_kind_e kind;
  logic [3:0] nyb;
  logic       hex, term, byte_v, pend;
  logic [7:0] byte_val;

  brec_char_class u_class (
    .char_i (char_i),
    .kind_o (kind),
    .nyb_o  (nyb)
  );

  assign hex  = char_valid_i && (kind == CH_HEX);
  assign term = char_valid_i && (kind == CH_TERM);

  brec_nybble_pair u_pair (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hex_i    (hex),
    .term_i   (term),
    .nyb_i    (nyb),
    .byte_v_o (byte_v),
    .byte_o   (byte_val),
    .pend_o   (pend)
  );

  brec_record_fsm #(
    .ADDR_BYTES (ADDR_BYTES),
    .LEN_W      (LEN_W)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .hex_i         (hex),
    .term_i        (term),
    .byte_v_i      (byte_v),
    .byte_i        (byte_val),
    .pend_i        (pend),
    .data_valid_o  (data_valid_o),
    .data_addr_o   (data_addr_o),
    .data_byte_o   (data_byte_o),
    .rec_mode_o    (rec_mode_o),
    .start_valid_o (start_valid_o),
    .start_addr_o  (start_addr_o),
    .err_o         (err_o)
  );

  assert_reset_quiet_R11: assert property (@(posedge clk_i)
    !rst_ni |=> !(data_valid_o || start_valid_o || err_o));
endmodule

// File: tb/brec_decoder_tb.sv
module brec_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cv = 1'b0;
  logic [7:0]  ch = 8'h00;
  logic        data_valid, start_valid, err;
  logic [31:0] data_addr, start_addr;
  logic [7:0]  data_byte;
  logic [1:0]  mode;

  int n_chk = 0, n_err = 0, err_cnt = 0;
  logic [41:0] dq[$];
  logic [33:0] sq[$];

  always #5 clk = ~clk;

  brec_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .char_valid_i(cv), .char_i(ch),
    .data_valid_o(data_valid), .data_addr_o(data_addr), .data_byte_o(data_byte),
    .rec_mode_o(mode), .start_valid_o(start_valid), .start_addr_o(start_addr),
    .err_o(err)
  );

  always @(negedge clk) if (rst_n) begin
    if (data_valid)  dq.push_back({mode, data_addr, data_byte});
    if (start_valid) sq.push_back({mode, start_addr});
    if (err)         err_cnt++;
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear();
    dq.delete(); sq.delete(); err_cnt = 0;
  endtask

  task automatic send(string s);
    for (int i = 0; i < s.len(); i++) begin
      @(negedge clk); cv = 1'b1; ch = s[i];
    end
    @(negedge clk); cv = 1'b0; ch = 8'h00;
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_data(string req, logic [31:0] base, string d, logic [1:0] m);
    check({req, " count"}, dq.size(), d.len());
    for (int i = 0; i < d.len() && i < dq.size(); i++)
      check(req, dq[i], {m, base + 32'(i), d[i]});
  endtask

  task automatic t_reset();
    check("R11 data", data_valid, 0);
    check("R11 start", start_valid, 0);
    check("R11 err", err, 0);
  endtask

  task automatic t_hello(); // R1 R4 R5
    clear();
    send("000000000D48656C6C6F2C20576F726C640A\n");
    expect_data("R5 hello", 32'h0, "Hello, World\n", 2'd0);
    check("R1 no err", err_cnt, 0);
  endtask

  task automatic t_mode(); // R4: E3 -> mode 3, reserved set, len 3
    clear();
    send("12345678E3AABBCC\r");
    expect_data("R4 mode", 32'h12345678, "\252\273\314", 2'd3);
    check("R4 no err", err_cnt, 0);
  endtask

  task automatic t_ignore(); // R2
    clear();
    send("0a000g0100:01AzB\n");
    expect_data("R2 ignore", 32'h100, "\253", 2'd0);
    check("R2 no err", err_cnt, 0);
  endtask

  task automatic t_start(); // R6
    clear();
    send("8000400000\n");
    send("0000FFFF40\n");
    check("R6 count", sq.size(), 2);
    if (sq.size() == 2) begin
      check("R6 addr0", sq[0], {2'd0, 32'h80004000});
      check("R6 addr1", sq[1], {2'd1, 32'h0000FFFF});
    end
    check("R6 no data", dq.size(), 0);
    check("R6 no err", err_cnt, 0);
  endtask

  task automatic t_short_hdr(); // R7 R3
    clear();
    send("001122\n");
    check("R7 hdr err", err_cnt, 1);
    check("R7 hdr no data", dq.size(), 0);
    clear();
    send("000000200155\n");
    expect_data("R3 next record", 32'h20, "U", 2'd0);
    check("R3 no err", err_cnt, 0);
  endtask

  task automatic t_short_data(); // R7
    clear();
    send("0000000003AABB\n");
    expect_data("R7 partial", 32'h0, "\252\273", 2'd0);
    check("R7 data err", err_cnt, 1);
  endtask

  task automatic t_odd(); // R8
    clear();
    send("0000000000F\n");
    check("R8 start seen", sq.size(), 1);
    check("R8 odd err", err_cnt, 1);
    clear();
    send("0\n");
    check("R8 lone digit err", err_cnt, 1);
  endtask

  task automatic t_empty(); // R9
    clear();
    send("\r\n\n");
    check("R9 no err", err_cnt, 0);
    check("R9 no data", dq.size(), 0);
    check("R9 no start", sq.size(), 0);
  endtask

  task automatic t_excess(); // R10
    clear();
    send("0000000001AACCDD\n");
    expect_data("R10 excess", 32'h0, "\252", 2'd0);
    check("R10 no err", err_cnt, 0);
  endtask

  task automatic t_wrap(); // R5 address wrap
    clear();
    send("FFFFFFFF021234\n");
    expect_data("R5 wrap", 32'hFFFFFFFF, "\022\064", 2'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_hello();
    t_mode();
    t_ignore();
    t_start();
    t_short_hdr();
    t_short_data();
    t_odd();
    t_empty();
    t_excess();
    t_wrap();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule